// File: doc/BRIEF.md
# Multi-Mode Configurable Register Cell

This block is the one-bit storage element of a programmable logic cell. A static configuration word chooses how the bit behaves: as a D, T, JK or SR flip-flop, or as a transparent latch. The same word also chooses where the data comes from, which clock drives the bit, whether a product-term enable gates that clock, and which signals may force the bit low or high at any moment. The stored value leaves the block on a single output.

The cell is modelled inside one fast system clock domain. Every logic clock (three global clocks and one product-term clock) is an ordinary input that the cell samples on each system clock edge. A rising edge of the chosen logic clock is seen when that clock reads 1 in the current sample and read 0 in the previous sample. The flip-flop then takes its new value at that same system edge. Clear and preset reach the output in the same cycle as they are applied, with no system edge in between. An open latch also passes its data straight to the output. While clear or preset is held, it also loads the stored bit, so the value remains after the forcing signal is released.

Top module: `mcell_reg`

## Requirements
- R1: The data source comes from configuration bits [4:3]: 0 selects `xor_in`, 1 selects `pt_data`, 2 selects `pin_in`, and 3 acts like 0. D, T and latch modes use the selected data.
- R2: Configuration bits [6:5] pick the clock: values 0 to 2 select `gclk[0]` to `gclk[2]`, and value 3 selects `pt_clk`. In flip-flop modes the stored bit changes only at a system edge where the chosen clock samples 1 and sampled 0 on the previous system edge.
- R3: When bit 7 is 1 and a global clock is chosen, a low `pt_ce` at the sampled rising edge leaves the bit unchanged, and a low `pt_ce` also keeps a latch closed. With the product-term clock, bit 7 and `pt_ce` have no effect.
- R4: Mode bits [2:0] = 0 select D: a rising edge loads the data. Mode 1 selects T: a rising edge inverts the bit when the data is 1 and holds it when the data is 0. Modes 5 to 7 behave as D.
- R5: Mode 4 selects a transparent latch. While the chosen clock is high and enabled, `q` equals the data in the same cycle, and the bit keeps that value. While the clock is low, the bit holds.
- R6: Mode 2 selects JK, with J taken from `xor_in` and K from `pt_data`. At a rising edge, J=1 K=0 sets the bit, J=0 K=1 clears it, J=K=1 inverts it, and J=K=0 holds it.
- R7: Mode 3 selects SR, with S taken from `xor_in` and R from `pt_data`. At a rising edge, S=1 R=0 sets the bit, S=0 R=1 clears it, and both 0 or both 1 hold it.
- R8: Bits [9:8] pick the clear source: 0 disables it, 1 uses `gclr`, 2 uses `pt_ar`, and 3 uses the OR of the two. An active clear drives `q` to 0 in the same cycle.
- R9: Bit 10 set to 1 enables `pt_ap` as the preset, which drives `q` to 1 in the same cycle. When clear and preset are active together, `q` is 0.
- R10: Clear and preset override the clock and the latch. The forced value stays in the cell after the forcing signal is released, until a later clock event changes it.
- R11: A low `rst_n` at a system edge clears the bit. A logic clock that is already high when reset ends is not counted as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 11 | Static configuration word (mode, data, clock, enable, clear, preset) |
| xor_in | input | 1 | XOR-stage result; also J and S |
| pt_data | input | 1 | Spare product term; also K and R |
| pin_in | input | 1 | Value read from the I/O pin |
| gclk | input | 3 | Global logic clocks |
| pt_clk | input | 1 | Product-term logic clock |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_ar | input | 1 | Product-term clear |
| pt_ap | input | 1 | Product-term preset |
| q | output | 1 | Stored value |

## Verification
Two functions can fall in the same cycle: a clock event (a rising edge or an open latch) and a forcing clear or preset. A third case is a clear together with a preset. The sweep covers every mode, data source, clock source, enable setting, clear source and preset setting. Each configuration receives random clocks and data, plus occasional clear and preset pulses. The collisions therefore arise naturally, and they are judged against a reference model in the bench that applies clear over preset, then preset over any clock event. Directed steps then confirm that a forced value survives its release, and that a clock held high through reset is not counted as an edge.

// File: rtl/mcell_reg_pkg.sv
// Package: shared encodings of the register cell configuration fields.
// Assumes: field values are fixed while the cell runs.
package mcell_reg_pkg;

    localparam int MODE_W  = 3;
    localparam int DSEL_W  = 2;
    localparam int ARSEL_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_D     = 3'd0,
        MD_T     = 3'd1,
        MD_JK    = 3'd2,
        MD_SR    = 3'd3,
        MD_LATCH = 3'd4
    } mode_e;

    typedef enum logic [DSEL_W-1:0] {
        DS_XOR   = 2'd0,
        DS_PTERM = 2'd1,
        DS_PIN   = 2'd2,
        DS_ALT   = 2'd3
    } dsel_e;

    typedef enum logic [ARSEL_W-1:0] {
        AR_OFF   = 2'd0,
        AR_GCLR  = 2'd1,
        AR_PTERM = 2'd2,
        AR_BOTH  = 2'd3
    } arsel_e;

endpackage

// File: rtl/mcell_src_sel.sv
// Module: chooses the data value, the logic clock and the clock-enable
// qualification for the register cell.
// Assumes: select fields are static; a clock select at or above NUM_GCLK
// means the product-term clock, which the enable never gates.
module mcell_src_sel
    import mcell_reg_pkg::*;
#(
    parameter int NUM_GCLK = 3,
    parameter int KSEL_W   = 2
) (
    input  dsel_e               dsel,
    input  logic [KSEL_W-1:0]   ksel,
    input  logic                ce_use,
    input  logic                xor_in,
    input  logic                pt_data,
    input  logic                pin_in,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                pt_ce,
    output logic                d_sel,
    output logic                sel_clk,
    output logic                clk_ok
);

    logic is_global;

    // Data multiplexer: pick XOR result, spare term or pin value.
    always_comb begin
        case (dsel)
            DS_PTERM: d_sel = pt_data;
            DS_PIN:   d_sel = pin_in;
            default:  d_sel = xor_in;
        endcase
    end

    // Clock multiplexer: one of the global clocks, else the product-term clock.
    always_comb begin
        sel_clk   = pt_clk;
        is_global = 1'b0;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (ksel == KSEL_W'(i)) begin
                sel_clk   = gclk[i];
                is_global = 1'b1;
            end
        end
    end

    // Enable qualification: applies only to a global clock with enable use set.
    always_comb begin
        clk_ok = !(ce_use && is_global) || pt_ce;
    end

endmodule

// File: rtl/mcell_async_ctl.sv
// Module: resolves the forcing clear and preset requests from their
// configured sources.
// Assumes: priority between the two is applied by the consumer.
module mcell_async_ctl
    import mcell_reg_pkg::*;
(
    input  arsel_e arsel,
    input  logic   ap_use,
    input  logic   gclr,
    input  logic   pt_ar,
    input  logic   pt_ap,
    output logic   clr_act,
    output logic   pre_act
);

    // Clear source: off, global clear, product term, or both ORed.
    always_comb begin
        case (arsel)
            AR_GCLR:  clr_act = gclr;
            AR_PTERM: clr_act = pt_ar;
            AR_BOTH:  clr_act = gclr | pt_ar;
            default:  clr_act = 1'b0;
        endcase
    end

    // Preset source: product term when enabled, else off.
    always_comb begin
        pre_act = ap_use & pt_ap;
    end

endmodule

// File: rtl/mcell_next_state.sv
// Module: computes the value a flip-flop mode takes at a clock edge.
// Assumes: latch mode is handled outside; unknown modes act as D.
module mcell_next_state
    import mcell_reg_pkg::*;
(
    input  mode_e mode,
    input  logic  cur,
    input  logic  d_sel,
    input  logic  jset,
    input  logic  kclr,
    output logic  nxt
);

    // Mode table for D, T, JK and SR operation.
    always_comb begin
        case (mode)
            MD_T:  nxt = cur ^ d_sel;
            MD_JK: begin
                case ({jset, kclr})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    2'b11:   nxt = ~cur;
                    default: nxt = cur;
                endcase
            end
            MD_SR: begin
                case ({jset, kclr})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    default: nxt = cur;
                endcase
            end
            default: nxt = d_sel;
        endcase
    end

endmodule

// File: rtl/mcell_reg.sv
// Module: one-bit multi-mode register cell of a programmable logic cell.
// Samples the chosen logic clock on the system clock, detects its rising
// edge, and updates the bit by mode; clear and preset force the output in
// the same cycle and load the bit.
// Assumes: cfg is static; logic clocks are slower than the system clock.
module mcell_reg
    import mcell_reg_pkg::*;
#(
    parameter  int NUM_GCLK = 3,
    localparam int KSEL_W   = $clog2(NUM_GCLK + 1),
    localparam int CFG_W    = MODE_W + DSEL_W + KSEL_W + 1 + ARSEL_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg,
    input  logic                xor_in,
    input  logic                pt_data,
    input  logic                pin_in,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                pt_ce,
    input  logic                gclr,
    input  logic                pt_ar,
    input  logic                pt_ap,
    output logic                q
);

    localparam int P_MODE = 0;
    localparam int P_DSEL = P_MODE + MODE_W;
    localparam int P_KSEL = P_DSEL + DSEL_W;
    localparam int P_CE   = P_KSEL + KSEL_W;
    localparam int P_AR   = P_CE + 1;
    localparam int P_AP   = P_AR + ARSEL_W;

    mode_e             mode;
    dsel_e             dsel;
    arsel_e            arsel;
    logic [KSEL_W-1:0] ksel;
    logic              ce_use;
    logic              ap_use;
    logic              is_latch;

    logic d_sel, sel_clk, clk_ok;
    logic clr_act, pre_act;
    logic nxt;
    logic state_q, clk_q, rise;

    // Configuration decode into typed fields.
    always_comb begin
        mode     = mode_e'(cfg[P_MODE +: MODE_W]);
        dsel     = dsel_e'(cfg[P_DSEL +: DSEL_W]);
        ksel     = cfg[P_KSEL +: KSEL_W];
        ce_use   = cfg[P_CE];
        arsel    = arsel_e'(cfg[P_AR +: ARSEL_W]);
        ap_use   = cfg[P_AP];
        is_latch = (mode == MD_LATCH);
    end

    mcell_src_sel #(
        .NUM_GCLK (NUM_GCLK),
        .KSEL_W   (KSEL_W)
    ) u_src (
        .dsel    (dsel),
        .ksel    (ksel),
        .ce_use  (ce_use),
        .xor_in  (xor_in),
        .pt_data (pt_data),
        .pin_in  (pin_in),
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .pt_ce   (pt_ce),
        .d_sel   (d_sel),
        .sel_clk (sel_clk),
        .clk_ok  (clk_ok)
    );

    mcell_async_ctl u_async (
        .arsel   (arsel),
        .ap_use  (ap_use),
        .gclr    (gclr),
        .pt_ar   (pt_ar),
        .pt_ap   (pt_ap),
        .clr_act (clr_act),
        .pre_act (pre_act)
    );

    mcell_next_state u_next (
        .mode  (mode),
        .cur   (state_q),
        .d_sel (d_sel),
        .jset  (xor_in),
        .kclr  (pt_data),
        .nxt   (nxt)
    );

    // Rising-edge detect of the chosen logic clock.
    always_comb begin
        rise = sel_clk & ~clk_q;
    end

    // Storage: system reset, then clear, preset, latch or edge update.
    always_ff @(posedge clk) begin
        clk_q <= sel_clk;
        if (!rst_n) begin
            state_q <= 1'b0;
        end else if (clr_act) begin
            state_q <= 1'b0;
        end else if (pre_act) begin
            state_q <= 1'b1;
        end else if (is_latch) begin
            if (sel_clk && clk_ok) begin
                state_q <= d_sel;
            end
        end else if (rise && clk_ok) begin
            state_q <= nxt;
        end
    end

    // Output: forcing controls first, then open latch, else stored bit.
    always_comb begin
        if (clr_act) begin
            q = 1'b0;
        end else if (pre_act) begin
            q = 1'b1;
        end else if (is_latch && sel_clk && clk_ok) begin
            q = d_sel;
        end else begin
            q = state_q;
        end
    end

    AST_CLEAR_LOADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (state_q == 1'b0)); // R8
    AST_CLEAR_BEATS_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_act && pre_act) |=> !state_q); // R9
    AST_PRESET_LOADS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_act && !clr_act) |=> state_q); // R10
    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_latch && !rise && !clr_act && !pre_act) |=> $stable(state_q)); // R2
    AST_ENABLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_ok && !clr_act && !pre_act) |=> $stable(state_q)); // R3
    AST_T_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_T && rise && clk_ok && d_sel && !clr_act && !pre_act)
        |=> (state_q != $past(state_q))); // R4
    AST_LATCH_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (is_latch && sel_clk && clk_ok && !clr_act && !pre_act)
        |=> (state_q == $past(d_sel))); // R5

endmodule

// File: tb/mcell_reg_bench.sv
// Bench: sweeps every configuration with random clocks, data and forcing
// pulses against an independent reference model, then runs directed steps.
module mcell_reg_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg = '0;
    logic        xor_in = 1'b0, pt_data = 1'b0, pin_in = 1'b0;
    logic [2:0]  gclk = '0;
    logic        pt_clk = 1'b0, pt_ce = 1'b1;
    logic        gclr = 1'b0, pt_ar = 1'b0, pt_ap = 1'b0;
    logic        q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic m_state = 1'b0;
    logic m_prev  = 1'b0;

    mcell_reg u_mcell_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .xor_in  (xor_in),
        .pt_data (pt_data),
        .pin_in  (pin_in),
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .pt_ce   (pt_ce),
        .gclr    (gclr),
        .pt_ar   (pt_ar),
        .pt_ap   (pt_ap),
        .q       (q)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic f_data();
        case (cfg[4:3])
            2'd1:    return pt_data;
            2'd2:    return pin_in;
            default: return xor_in;
        endcase
    endfunction

    function automatic logic f_clk();
        if (cfg[6:5] == 2'd3) return pt_clk;
        return gclk[cfg[6:5]];
    endfunction

    function automatic logic f_ok();
        return !(cfg[7] && cfg[6:5] != 2'd3) || pt_ce;
    endfunction

    function automatic logic f_clr();
        return (cfg[8] & gclr) | (cfg[9] & pt_ar);
    endfunction

    function automatic logic f_pre();
        return cfg[10] & pt_ap;
    endfunction

    function automatic logic f_q();
        if (f_clr()) return 1'b0;
        if (f_pre()) return 1'b1;
        if (cfg[2:0] == 3'd4 && f_clk() && f_ok()) return f_data();
        return m_state;
    endfunction

    function automatic string f_tag();
        if (f_clr()) return f_pre() ? "R9" : "R8";
        if (f_pre()) return "R9";
        if (cfg[2:0] == 3'd4) return "R5";
        if (!f_ok()) return "R3";
        if (cfg[6:5] == 2'd3) return "R2";
        case (cfg[2:0])
            3'd2:    return "R6";
            3'd3:    return "R7";
            3'd1:    return "R4";
            default: return (cfg[4:3] != 2'd0) ? "R1" : "R4";
        endcase
    endfunction

    // Reference update at a system edge, from the requirements.
    task automatic model_edge();
        logic c, d, r;
        c = f_clk();
        d = f_data();
        r = c & ~m_prev;
        if (!rst_n)              m_state = 1'b0;
        else if (f_clr())        m_state = 1'b0;
        else if (f_pre())        m_state = 1'b1;
        else if (cfg[2:0] == 3'd4) begin
            if (c && f_ok())     m_state = d;
        end else if (r && f_ok()) begin
            case (cfg[2:0])
                3'd1: m_state = m_state ^ d;
                3'd2: m_state = (xor_in && pt_data) ? ~m_state :
                                xor_in ? 1'b1 : pt_data ? 1'b0 : m_state;
                3'd3: m_state = (xor_in == pt_data) ? m_state : xor_in;
                default: m_state = d;
            endcase
        end
        m_prev = c;
    endtask

    task automatic check(input logic exp, input string tag);
        total++;
        if (q !== exp) begin
            bad++;
            $display("FAIL %s cfg=%b q=%b expected=%b", tag, cfg, q, exp);
        end
    endtask

    // One system cycle: check output at low phase, then advance the model.
    task automatic step(input string tag);
        #1;
        check(f_q(), (tag == "") ? f_tag() : tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(11);
        @(negedge clk);
        @(negedge clk);
        // R11: reset state
        check(1'b0, "R11");
        step("R11");
        rst_n = 1'b1;

        // Sweep: mode 0..5, data source, clock source, enable, clear, preset
        for (int md = 0; md < 6; md++)
        for (int ds = 0; ds < 3; ds++)
        for (int ks = 0; ks < 4; ks++)
        for (int ce = 0; ce < 2; ce++)
        for (int ar = 0; ar < 4; ar++)
        for (int ap = 0; ap < 2; ap++) begin
            cfg = {ap[0], ar[1:0], ce[0], ks[1:0], ds[1:0], md[2:0]};
            for (int n = 0; n < 14; n++) begin
                r       = $urandom;
                gclk    = r[2:0];
                pt_clk  = r[3];
                xor_in  = r[4];
                pt_data = r[5];
                pin_in  = r[6];
                pt_ce   = r[7] | r[8];
                gclr    = (r[11:9] == 3'd0);
                pt_ar   = (r[14:12] == 3'd0);
                pt_ap   = (r[17:15] == 3'd0);
                step("");
            end
        end

        // R10: preset in D mode, release, value persists without clock
        cfg = 11'b1_00_0_00_00_000;
        gclk = '0; gclr = 1'b0; pt_ar = 1'b0; xor_in = 1'b0; pt_ap = 1'b1;
        step("R10");
        pt_ap = 1'b0;
        for (int n = 0; n < 3; n++) begin
            #1; check(1'b1, "R10");
            @(posedge clk); model_edge(); @(negedge clk);
        end
        // R10: clear overrides an open latch, value stays 0 after release
        cfg = 11'b0_10_0_00_00_100;
        xor_in = 1'b1; gclk[0] = 1'b1; pt_ar = 1'b1;
        #1; check(1'b0, "R10");
        @(posedge clk); model_edge(); @(negedge clk);
        gclk[0] = 1'b0; pt_ar = 1'b0;
        #1; check(1'b0, "R10");
        @(posedge clk); model_edge(); @(negedge clk);

        // R11: clock high through reset release is not an edge
        cfg = 11'b0_00_0_00_00_000;
        gclk[0] = 1'b1; xor_in = 1'b1;
        rst_n = 1'b0;
        @(posedge clk); model_edge(); @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 3; n++) begin
            #1; check(1'b0, "R11");
            @(posedge clk); model_edge(); @(negedge clk);
        end
        gclk[0] = 1'b0;
        step("R2");
        gclk[0] = 1'b1;
        @(posedge clk); model_edge(); @(negedge clk);
        #1; check(1'b1, "R2");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule